// File: doc/BRIEF.md
# Wiper Configuration I2C Target

This block is a serial-bus target that holds the settings of a stepping potentiometer. Its working wiper position sits next to a nonvolatile copy, which sets the value the wiper takes at power-up. The block also holds a step control byte, which is kept in nonvolatile form as well, and a volatile control byte. A write to a recall location reloads the working registers from the stored copies. The nonvolatile storage is modelled as internal registers. After each commit, a programmable busy timer runs, and the target refuses its address until the timer expires.

A host reaches the registers through an address pointer. The second byte of a write transaction loads the pointer. Each later data byte is written at the pointer, and the pointer then advances. A read streams bytes out from the pointer and advances it after each byte. The register outputs drive the stepping controller. The configuration-written pulse tells that controller to restart its stepping sequence.

Top module: `wiper_cfg_i2c`

## Requirements
- R1: The target acknowledges address byte 0x50 (write) or 0x51 (read), which is the 7-bit address 0x28. Any other address byte is not acknowledged. The rest of that transfer, up to the next START, is then ignored: no ACK is driven and no register changes.
- R2: In a write transfer, the byte after the address byte loads the pointer. Every later byte is acknowledged and written to the pointer location, and the pointer then increments by one.
- R3: In a read transfer, the target returns the byte at the pointer, MSB first, and increments the pointer after each byte. A master ACK asks for the next byte. A master NACK ends the read, and SDA is released. A dummy write of a register number, followed by a repeated START and a read, returns that register.
- R4: Register 0x00 is the working wiper, 0x01 is step control, 0x02 is control, and 0xAA is the recall location. Any other location reads as 0x00, and writes to it are acknowledged with no effect.
- R5: After reset, the wiper is 0x40, step control is 0x00 and control is 0x00, and SDA is not pulled low.
- R6: When control bit 7 is 0, a write to 0x00 also stages the nonvolatile wiper copy. When bit 7 is 1, only the working wiper changes. A read of 0x00 returns the working wiper.
- R7: A staged value is committed to the nonvolatile copy only at a STOP. A START or repeated START that comes before the STOP discards it.
- R8: After a commit, the target does not acknowledge its address for NV_BUSY_CYCLES clocks. A write that stages nothing starts no busy time.
- R9: A write to step control always stages its nonvolatile copy, whatever the value of control bit 7.
- R10: Writing a byte with bit 7 set to 0xAA reloads the wiper and step control from their nonvolatile copies and clears control to 0x00. Location 0xAA always reads 0x00.
- R11: The configuration-written pulse is high for exactly one clock for each accepted write to 0x00, 0x01 or 0x02, and for each recall. It stays low for writes to any other location.
- R12: A written register shows its new value at the outputs by the time the target's ACK for the data byte is sampled. Registers change at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; loads the factory values |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| wiper_o | output | 8 | Working wiper position |
| step_ctl_o | output | 8 | Step control byte |
| ctrl_o | output | 8 | Control byte; bit 7 selects the working-only write mode |
| cfg_wr_pulse_o | output | 1 | One-clock pulse after each accepted configuration write |

## Verification
The assertions assume a single master. That master holds SDA steady while SCL is high, except at START and STOP, and keeps every SCL phase much longer than the two-flop synchroniser plus the majority window. Given that, the target only changes its SDA drive while SCL is low. The bench master uses 20-clock half bit times and moves SDA halfway through the low phase, so it stays well within those assumptions. It models the open-drain line as the AND of its own release and the target's pull, and it does not start a write while a commit is busy unless the test is checking for the NACK.

// File: rtl/wcfg_pkg.sv
package wcfg_pkg;
  localparam logic [7:0] REG_WIPER  = 8'h00;
  localparam logic [7:0] REG_STEP   = 8'h01;
  localparam logic [7:0] REG_CTRL   = 8'h02;
  localparam logic [7:0] REG_RECALL = 8'hAA;

  localparam logic [7:0] WIPER_FACTORY = 8'h40;
  localparam logic [7:0] STEP_FACTORY  = 8'h00;
  localparam logic [7:0] CTRL_POWERUP  = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } bus_state_e;

  // Majority vote over the first n bits of v.
  function automatic logic majority(input logic [15:0] v, input int n);
    int ones;
    ones = 0;
    for (int i = 0; i < 16; i++) begin
      if (i < n && v[i]) ones++;
    end
    return (ones * 2) > n;
  endfunction

  // Read data for a pointer value.
  function automatic logic [7:0] read_mux(input logic [7:0] addr,
                                          input logic [7:0] wiper,
                                          input logic [7:0] step,
                                          input logic [7:0] ctrl);
    case (addr)
      REG_WIPER: return wiper;
      REG_STEP:  return step;
      REG_CTRL:  return ctrl;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    return p + 8'd1;
  endfunction
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter import wcfg_pkg::*; #(
  parameter int TAPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic lvl_o,
  output logic lvl_prev_o
);
  logic [1:0]      sync_q;
  logic [TAPS-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '1;
      hist_q     <= '1;
      lvl_o      <= 1'b1;
      lvl_prev_o <= 1'b1;
    end else begin
      sync_q     <= {sync_q[0], raw_i};
      hist_q     <= {hist_q[TAPS-2:0], sync_q[1]};
      lvl_o      <= majority(16'(hist_q), TAPS);
      lvl_prev_o <= lvl_o;
    end
  end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm import wcfg_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_lvl,
  input  logic       scl_prev,
  input  logic       sda_lvl,
  input  logic       sda_prev,
  input  logic       busy,
  input  logic [7:0] rd_data,
  output logic [7:0] ptr,
  output logic       sda_pull,
  output logic       wr_stb,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       start_ev,
  output logic       stop_ev,
  output logic       addr_ack
);
  bus_state_e state;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic [7:0] tx;
  logic       rd_mode;
  logic       first;
  logic       nack;

  logic scl_rise, scl_fall;
  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;
  assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitn     <= '0;
      sh       <= '0;
      tx       <= '0;
      rd_mode  <= 1'b0;
      first    <= 1'b0;
      nack     <= 1'b1;
      ptr      <= '0;
      sda_pull <= 1'b0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      addr_ack <= 1'b0;
    end else begin
      wr_stb   <= 1'b0;
      addr_ack <= 1'b0;
      if (start_ev) begin
        state    <= ST_ADDR;
        bitn     <= '0;
        sda_pull <= 1'b0;
      end else if (stop_ev) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_lvl};
              bitn <= bitn + 4'd1;
            end else if (scl_fall && bitn == 4'd8) begin
              if (sh[7:1] == DEV_ADDR && !busy) begin
                state    <= ST_AACK;
                sda_pull <= 1'b1;
                rd_mode  <= sh[0];
                addr_ack <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bitn <= '0;
              if (rd_mode) begin
                tx       <= rd_data;
                sda_pull <= ~rd_data[7];
                ptr      <= ptr_next(ptr);
                state    <= ST_RDATA;
              end else begin
                sda_pull <= 1'b0;
                first    <= 1'b1;
                state    <= ST_WDATA;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_lvl};
              bitn <= bitn + 4'd1;
            end else if (scl_fall && bitn == 4'd8) begin
              sda_pull <= 1'b1;
              state    <= ST_WACK;
              if (first) begin
                ptr <= sh;
              end else begin
                wr_stb  <= 1'b1;
                wr_addr <= ptr;
                wr_data <= sh;
                ptr     <= ptr_next(ptr);
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              first    <= 1'b0;
              bitn     <= '0;
              state    <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bitn == 4'd7) begin
                sda_pull <= 1'b0;
                state    <= ST_RACK;
              end else begin
                tx       <= {tx[6:0], 1'b0};
                sda_pull <= ~tx[6];
                bitn     <= bitn + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack <= sda_lvl;
            end else if (scl_fall) begin
              if (nack) begin
                state <= ST_IDLE;
              end else begin
                tx       <= rd_data;
                sda_pull <= ~rd_data[7];
                ptr      <= ptr_next(ptr);
                bitn     <= '0;
                state    <= ST_RDATA;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && scl_prev) |-> $stable(sda_pull));
endmodule

// File: rtl/wcfg_regs.sv
module wcfg_regs import wcfg_pkg::*; #(
  parameter int NV_BUSY_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       start_ev,
  input  logic       stop_ev,
  output logic [7:0] wiper,
  output logic [7:0] step,
  output logic [7:0] ctrl,
  output logic       busy,
  output logic       cfg_pulse
);
  localparam int BW = $clog2(NV_BUSY_CYCLES + 1);

  logic [7:0]    nv_wiper, nv_step;
  logic [7:0]    pend_wv, pend_sv;
  logic          pend_w, pend_s;
  logic [BW-1:0] busy_cnt;

  assign busy = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_wiper  <= WIPER_FACTORY;
      nv_step   <= STEP_FACTORY;
      wiper     <= WIPER_FACTORY;
      step      <= STEP_FACTORY;
      ctrl      <= CTRL_POWERUP;
      pend_w    <= 1'b0;
      pend_s    <= 1'b0;
      pend_wv   <= '0;
      pend_sv   <= '0;
      busy_cnt  <= '0;
      cfg_pulse <= 1'b0;
    end else begin
      cfg_pulse <= 1'b0;
      if (stop_ev) begin
        if (pend_w) nv_wiper <= pend_wv;
        if (pend_s) nv_step  <= pend_sv;
        if (pend_w || pend_s) busy_cnt <= BW'(NV_BUSY_CYCLES);
        pend_w <= 1'b0;
        pend_s <= 1'b0;
      end else begin
        if (busy) busy_cnt <= busy_cnt - 1'b1;
        if (start_ev) begin
          pend_w <= 1'b0;
          pend_s <= 1'b0;
        end
      end
      if (wr_stb) begin
        case (wr_addr)
          REG_WIPER: begin
            wiper     <= wr_data;
            cfg_pulse <= 1'b1;
            if (!ctrl[7]) begin
              pend_w  <= 1'b1;
              pend_wv <= wr_data;
            end
          end
          REG_STEP: begin
            step      <= wr_data;
            cfg_pulse <= 1'b1;
            pend_s    <= 1'b1;
            pend_sv   <= wr_data;
          end
          REG_CTRL: begin
            ctrl      <= wr_data;
            cfg_pulse <= 1'b1;
          end
          REG_RECALL: begin
            if (wr_data[7]) begin
              wiper     <= nv_wiper;
              step      <= nv_step;
              ctrl      <= CTRL_POWERUP;
              cfg_pulse <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R12
  wiper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(wiper));

  // R7
  nv_commit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_ev |=> $stable(nv_wiper));

  // R6
  volatile_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == REG_WIPER && ctrl[7]) |=> $stable(pend_w));
endmodule

// File: rtl/wiper_cfg_i2c.sv
module wiper_cfg_i2c import wcfg_pkg::*; #(
  parameter logic [6:0] DEV_ADDR       = 7'h28,
  parameter int         FILT_TAPS      = 3,
  parameter int         NV_BUSY_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [7:0] wiper_o,
  output logic [7:0] step_ctl_o,
  output logic [7:0] ctrl_o,
  output logic       cfg_wr_pulse_o
);
  logic       scl_lvl, scl_prev, sda_lvl, sda_prev;
  logic       busy, wr_stb, start_ev, stop_ev, addr_ack;
  logic [7:0] ptr, wr_addr, wr_data, rd_data;

  i2c_line_filter #(.TAPS(FILT_TAPS)) u_scl_flt (
    .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .lvl_o(scl_lvl), .lvl_prev_o(scl_prev));
  i2c_line_filter #(.TAPS(FILT_TAPS)) u_sda_flt (
    .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .lvl_o(sda_lvl), .lvl_prev_o(sda_prev));

  assign rd_data = read_mux(ptr, wiper_o, step_ctl_o, ctrl_o);

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_lvl), .scl_prev(scl_prev), .sda_lvl(sda_lvl), .sda_prev(sda_prev),
    .busy(busy), .rd_data(rd_data), .ptr(ptr), .sda_pull(sda_pull_o),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_ev(start_ev), .stop_ev(stop_ev), .addr_ack(addr_ack));

  wcfg_regs #(.NV_BUSY_CYCLES(NV_BUSY_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .wiper(wiper_o), .step(step_ctl_o), .ctrl(ctrl_o),
    .busy(busy), .cfg_pulse(cfg_wr_pulse_o));

  // R8
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !addr_ack);

  // R11
  cfg_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_pulse_o |=> !cfg_wr_pulse_o);
endmodule

// File: tb/sim_wiper_cfg_i2c.sv
module sim_wiper_cfg_i2c;
  localparam int H = 20;
  localparam int BUSY = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull;
  logic [7:0] wiper, step, ctrl;
  logic cfg_pulse;
  logic sda_line;
  int total = 0;
  int bad = 0;
  int cfg_cnt = 0;

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  wiper_cfg_i2c #(.NV_BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .wiper_o(wiper), .step_ctl_o(step), .ctrl_o(ctrl),
    .cfg_wr_pulse_o(cfg_pulse));

  always @(negedge clk) if (cfg_pulse) cfg_cnt++;

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wc(H/2);
    m_scl = 1'b1; wc(H);
    m_sda = 1'b0; wc(H);
    m_scl = 1'b0; wc(H/2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wc(H/2);
    m_scl = 1'b1; wc(H);
    m_sda = 1'b1; wc(H);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; wc(H/2);
    m_scl = 1'b1; wc(H);
    m_scl = 1'b0; wc(H/2);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wc(H/2);
    m_scl = 1'b1; wc(H/2);
    b = sda_line; wc(H/2);
    m_scl = 1'b0; wc(H/2);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(~give_ack);
  endtask

  // single write; with_stop=0 ends with repeated START then STOP
  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, input bit with_stop,
                        output logic all_ack);
    logic k0, k1, k2;
    bus_start();
    send_byte(8'h50, k0);
    send_byte(a, k1);
    send_byte(d, k2);
    if (!with_stop) bus_start();
    bus_stop();
    all_ack = k0 & k1 & k2;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    logic k;
    bus_start();
    send_byte(8'h50, k);
    send_byte(a, k);
    bus_start();
    send_byte(8'h51, k);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  // {register, written byte, expected read-back}
  localparam logic [23:0] VEC [8] = '{
    24'h00_5A_5A, 24'h01_1F_1F, 24'h02_80_80, 24'h00_11_11,
    24'h05_77_00, 24'hFF_33_00, 24'h02_00_00, 24'h01_65_65
  };

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ok, k;
    logic [7:0] d;
    int c0;
    wc(5);
    rst_n = 1'b1;
    wc(5);
    // R5 reset values
    check("R5 wiper", wiper, 8'h40);
    check("R5 step", step, 8'h00);
    check("R5 ctrl", ctrl, 8'h00);
    check("R5 sda", sda_pull, 0);

    // table walk: R4 map, R2 write, R3 dummy-write read, R11 pulse
    foreach (VEC[i]) begin
      c0 = cfg_cnt;
      bus_start();
      send_byte(8'h50, k);
      check("R1 addr ack", k, 1);
      send_byte(VEC[i][23:16], k);
      send_byte(VEC[i][15:8], k);
      check("R4 data ack", k, 1);
      bus_start();
      send_byte(8'h50, k);
      send_byte(VEC[i][23:16], k);
      bus_start();
      send_byte(8'h51, k);
      recv_byte(1'b0, d);
      bus_stop();
      check("R3 R4 readback", d, VEC[i][7:0]);
      check("R11 pulse count", cfg_cnt - c0, (VEC[i][23:16] <= 8'h02) ? 1 : 0);
    end

    // R1 wrong address: no ACK, following bytes ignored
    bus_start();
    send_byte(8'h52, k);
    check("R1 foreign addr nack", k, 0);
    send_byte(8'h00, k);
    check("R1 ignored byte", k, 0);
    send_byte(8'h99, k);
    bus_stop();
    check("R1 wiper unchanged", wiper, 8'h11);

    // R2 burst write, R12 value visible at ACK, R3 burst read
    bus_start();
    send_byte(8'h50, k);
    send_byte(8'h00, k);
    send_byte(8'h21, k);
    check("R12 wiper at ack", wiper, 8'h21);
    send_byte(8'h07, k);
    send_byte(8'h00, k);
    check("R2 burst step", step, 8'h07);
    bus_start();
    send_byte(8'h50, k);
    send_byte(8'h00, k);
    bus_start();
    send_byte(8'h51, k);
    recv_byte(1'b1, d);
    check("R3 burst byte0", d, 8'h21);
    recv_byte(1'b1, d);
    check("R3 burst byte1", d, 8'h07);
    recv_byte(1'b0, d);
    check("R3 burst byte2", d, 8'h00);
    wc(H);
    check("R3 sda released after nack", sda_pull, 0);
    bus_stop();

    // R7 R8 commit at STOP then busy NACK
    wr_reg(8'h00, 8'h33, 1'b1, ok);
    check("R6 write ack", ok, 1);
    bus_start();
    send_byte(8'h50, k);
    check("R8 busy nack", k, 0);
    bus_stop();
    wc(BUSY + 100);
    // R6 working-only mode: no busy, nv copy untouched
    wr_reg(8'h02, 8'h80, 1'b1, ok);
    check("R8 ack after busy", ok, 1);
    wr_reg(8'h00, 8'h44, 1'b1, ok);
    bus_start();
    send_byte(8'h50, k);
    check("R8 no busy in working mode", k, 1);
    bus_stop();
    rd_reg(8'h00, d);
    check("R6 read returns working", d, 8'h44);
    wr_reg(8'hAA, 8'h80, 1'b1, ok);
    check("R10 recall wiper", wiper, 8'h33);
    check("R10 recall ctrl", ctrl, 8'h00);
    rd_reg(8'hAA, d);
    check("R10 recall reads zero", d, 8'h00);

    // R7 repeated START discards staged value
    wr_reg(8'h00, 8'h55, 1'b0, ok);
    bus_start();
    send_byte(8'h50, k);
    check("R7 no busy after rstart", k, 1);
    bus_stop();
    wr_reg(8'hAA, 8'h80, 1'b1, ok);
    check("R7 nv kept", wiper, 8'h33);

    // R9 step control always committed
    wr_reg(8'h02, 8'h80, 1'b1, ok);
    wr_reg(8'h01, 8'h0A, 1'b1, ok);
    bus_start();
    send_byte(8'h50, k);
    check("R9 step commit busy", k, 0);
    bus_stop();
    wc(BUSY + 100);
    wr_reg(8'h01, 8'h0B, 1'b0, ok);
    check("R9 step working", step, 8'h0B);
    c0 = cfg_cnt;
    wr_reg(8'hAA, 8'h80, 1'b1, ok);
    check("R9 step recalled", step, 8'h0A);
    check("R11 recall pulse", cfg_cnt - c0, 1);
    c0 = cfg_cnt;
    wr_reg(8'hAA, 8'h00, 1'b1, ok);
    check("R11 no pulse bit7 clear", cfg_cnt - c0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule